// File: doc/BRIEF.md
# Memory-Mapped Performance Counter Unit

This block counts hardware events for a network fabric and raises an interrupt when a count wraps. It holds a bank of 32-bit event counters and one 64-bit cycle counter. All of them sit behind a small word-addressed register port, which offers single-cycle writes and combinational reads. Each event counter has a one-bit strobe input. The counter advances by one on every clock in which its strobe is high. A per-counter source tag records which fabric node the strobe comes from.

Software controls the block through bit-indexed set and clear registers. Bit n of these registers selects event counter n, and bit 31 selects the cycle counter. There are three such pairs: counter enable, interrupt enable and overflow status. One control word holds the global run bit and two self-clearing reset commands. A typical driver first preloads a counter near its wrap point. It then sets the counter's enable and interrupt-enable bits, turns the global run bit on, and services the interrupt. In the handler it reads the status word, rearms the counter and writes the status bits back to clear them.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset every counter, every enable bit, every status bit, the control word and every source tag are zero, and `irq` is low.
- R2: Event counter n is read and written at offset 0x008 + 8*n. The cycle counter's low word is at 0x0F8 and its high word is at 0x0FC. Any value written to these offsets reads back unchanged.
- R3: Offset 0xE00 always reads 0x0000_2008, which is the counter width in bits 15:8 and the event-counter count in bits 7:0. The source tag of counter n is at 0x400 + 4*n. It keeps a 4-bit node type in bits 12:9 and a 9-bit node id in bits 8:0, and all its other bits read 0.
- R4: A counter advances only while control bit 0 and its own enable bit are both 1. An event counter adds one per clock with its strobe high. The cycle counter adds one per clock and carries from its low word into its high word.
- R5: Writing ones to 0xC00 sets counter-enable bits, and writing ones to 0xC20 clears them. Writing ones to 0xC40 sets interrupt-enable bits, and writing ones to 0xC60 clears them. Zero bits leave state unchanged. Only bits 0..7 and bit 31 exist. Both offsets of a pair read back the current mask.
- R6: A counter that advances from all-ones wraps to zero. In that same clock it sets its status bit: bit n for an event counter, bit 31 for the cycle counter.
- R7: The status word reads at 0xC80 and at 0xCC0. Ones written to 0xC80 clear status bits, and ones written to 0xCC0 set them. A hardware wrap in the same clock as a clear leaves the bit set.
- R8: `irq` is high exactly when some status bit and its interrupt-enable bit are both 1. It stays high until software clears that status bit.
- R9: At 0xE04, bit 0 is the global run bit and reads back. Writing 1 to bit 1 zeroes all event counters, and writing 1 to bit 2 zeroes the cycle counter. Bits 1 and 2 always read 0.
- R10: Reads of unmapped offsets, including 0x00C, return zero. Writes to unmapped offsets change nothing.
- R11: A software write to a counter takes priority over counting in the same clock. The counter holds exactly the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when no read is requested |
| evt_strobe | input | 8 | One event pulse per counter per clock |
| irq | output | 1 | Level interrupt request |

## Verification
The bench drives wraps of an event counter and of the cycle counter across all-ones. A design that flagged the wrap one cycle late, or not at all, would leave the status bit or `irq` low when they are read. It lands a status clear in the same clock as a wrap. A design that let software win would lose the overflow. It also writes a counter while its strobe is high, which catches a design that adds one on top of the written value. It preloads the cycle low word with all-ones, which exposes a missing carry into the high word. Finally, it checks unmapped, odd and reserved offsets and the self-clearing reset bits. A decoder with loose matching would alias data there, or would leave reset commands visible in the control word.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  localparam logic [11:0] OFS_CNT_BASE = 12'h008;
  localparam logic [11:0] OFS_CYC_LO   = 12'h0F8;
  localparam logic [11:0] OFS_CYC_HI   = 12'h0FC;
  localparam logic [11:0] OFS_TAG_BASE = 12'h400;
  localparam logic [11:0] OFS_EN_SET   = 12'hC00;
  localparam logic [11:0] OFS_EN_CLR   = 12'hC20;
  localparam logic [11:0] OFS_IE_SET   = 12'hC40;
  localparam logic [11:0] OFS_IE_CLR   = 12'hC60;
  localparam logic [11:0] OFS_STS_CLR  = 12'hC80;
  localparam logic [11:0] OFS_STS_SET  = 12'hCC0;
  localparam logic [11:0] OFS_CFG      = 12'hE00;
  localparam logic [11:0] OFS_CTRL     = 12'hE04;

  localparam int CYC_BIT = 31;
  localparam int TAG_W   = 13;

  // Offset of event counter i
  function automatic logic [11:0] cnt_ofs(input int i);
    return 12'(32'(OFS_CNT_BASE) + 32'(i) * 8);
  endfunction

  // Offset of the source tag of counter i
  function automatic logic [11:0] tag_ofs(input int i);
    return 12'(32'(OFS_TAG_BASE) + 32'(i) * 4);
  endfunction

  // Implemented bit positions of the set/clear registers
  function automatic logic [31:0] slot_mask(input int n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    m[CYC_BIT] = 1'b1;
    return m;
  endfunction

  // Constant identification word: width in 15:8, count in 7:0
  function automatic logic [31:0] cfg_word(input int n, input int w);
    return {16'h0000, 8'(w), 8'(n)};
  endfunction

  // Set/clear register update; a hardware set beats a software clear
  function automatic logic [31:0] sc_next(input logic [31:0] q,
                                          input logic [31:0] set_v,
                                          input logic [31:0] clr_v,
                                          input logic [31:0] hw_v);
    return (q | set_v | hw_v) & ~(clr_v & ~hw_v);
  endfunction

endpackage

// File: rtl/pcu_event_counter.sv
module pcu_event_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         count_en,
  input  logic         strobe,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         clr,
  output logic [W-1:0] value,
  output logic         wrap
);
  logic step;

  assign step = count_en && strobe && !wr_en && !clr;
  assign wrap = step && (&value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     value <= '0;
    else if (clr)   value <= '0;
    else if (wr_en) value <= wr_data;
    else if (step)  value <= value + 1'b1;
  end
endmodule

// File: rtl/pcu_cycle_counter.sv
module pcu_cycle_counter #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_en,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              clr,
  output logic [2*HALF_W-1:0] value,
  output logic              wrap
);
  logic step;

  assign step = count_en && !wr_lo && !wr_hi && !clr;
  assign wrap = step && (&value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (clr) begin
      value <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) value[HALF_W-1:0]        <= wr_data;
      if (wr_hi) value[2*HALF_W-1:HALF_W] <= wr_data;
    end else if (step) begin
      value <= value + 1'b1;
    end
  end
endmodule

// File: rtl/pcu_setclr_reg.sv
module pcu_setclr_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] impl_mask,
  input  logic [31:0] set_v,
  input  logic [31:0] clr_v,
  input  logic [31:0] hw_v,
  output logic [31:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= pcu_pkg::sc_next(q, set_v, clr_v, hw_v) & impl_mask;
  end
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit #(
  parameter int NUM_EV = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [11:0]       bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_EV-1:0] evt_strobe,
  output logic              irq
);
  import pcu_pkg::*;

  localparam logic [31:0] MASK = slot_mask(NUM_EV);
  localparam logic [31:0] CFG  = cfg_word(NUM_EV, DATA_W);

  logic wr, rd;
  assign wr = bus_valid && bus_write;
  assign rd = bus_valid && !bus_write;

  // Control
  logic gl_en, ctrl_wr, ev_clr, cyc_clr;
  assign ctrl_wr = wr && (bus_addr == OFS_CTRL);
  assign ev_clr  = ctrl_wr && bus_wdata[1];
  assign cyc_clr = ctrl_wr && bus_wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gl_en <= 1'b0;
    else if (ctrl_wr) gl_en <= bus_wdata[0];
  end

  // Set/clear registers
  logic [31:0] en_q, ie_q, status;
  logic [31:0] hw_ovf;
  logic sts_clr_wr, sts_set_wr;
  assign sts_clr_wr = wr && (bus_addr == OFS_STS_CLR);
  assign sts_set_wr = wr && (bus_addr == OFS_STS_SET);

  pcu_setclr_reg u_en (
    .clk(clk), .rst_n(rst_n), .impl_mask(MASK),
    .set_v((wr && bus_addr == OFS_EN_SET) ? bus_wdata : 32'h0),
    .clr_v((wr && bus_addr == OFS_EN_CLR) ? bus_wdata : 32'h0),
    .hw_v(32'h0), .q(en_q));

  pcu_setclr_reg u_ie (
    .clk(clk), .rst_n(rst_n), .impl_mask(MASK),
    .set_v((wr && bus_addr == OFS_IE_SET) ? bus_wdata : 32'h0),
    .clr_v((wr && bus_addr == OFS_IE_CLR) ? bus_wdata : 32'h0),
    .hw_v(32'h0), .q(ie_q));

  pcu_setclr_reg u_sts (
    .clk(clk), .rst_n(rst_n), .impl_mask(MASK),
    .set_v(sts_set_wr ? bus_wdata : 32'h0),
    .clr_v(sts_clr_wr ? bus_wdata : 32'h0),
    .hw_v(hw_ovf), .q(status));

  // Event counters and source tags
  logic [NUM_EV-1:0][DATA_W-1:0] ev_val;
  logic [NUM_EV-1:0][TAG_W-1:0]  tag_q;
  logic [NUM_EV-1:0]             ev_wrap;

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    logic cnt_wr, tag_wr;
    assign cnt_wr = wr && (bus_addr == cnt_ofs(g));
    assign tag_wr = wr && (bus_addr == tag_ofs(g));

    pcu_event_counter #(.W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .count_en(gl_en && en_q[g]),
      .strobe(evt_strobe[g]),
      .wr_en(cnt_wr), .wr_data(bus_wdata), .clr(ev_clr),
      .value(ev_val[g]), .wrap(ev_wrap[g]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tag_q[g] <= '0;
      else if (tag_wr) tag_q[g] <= bus_wdata[TAG_W-1:0];
    end
  end

  // Cycle counter
  logic [2*DATA_W-1:0] cyc_val;
  logic cyc_wrap, cyc_wr_lo, cyc_wr_hi, cyc_wr;
  assign cyc_wr_lo = wr && (bus_addr == OFS_CYC_LO);
  assign cyc_wr_hi = wr && (bus_addr == OFS_CYC_HI);
  assign cyc_wr    = cyc_wr_lo || cyc_wr_hi;

  pcu_cycle_counter #(.HALF_W(DATA_W)) u_cyc (
    .clk(clk), .rst_n(rst_n),
    .count_en(gl_en && en_q[CYC_BIT]),
    .wr_lo(cyc_wr_lo), .wr_hi(cyc_wr_hi), .wr_data(bus_wdata),
    .clr(cyc_clr), .value(cyc_val), .wrap(cyc_wrap));

  always_comb begin
    hw_ovf = '0;
    hw_ovf[NUM_EV-1:0] = ev_wrap;
    hw_ovf[CYC_BIT]    = cyc_wrap;
  end

  // Read decode
  logic [DATA_W-1:0] rd_mux;
  logic              rd_hit;
  always_comb begin
    rd_mux = '0;
    rd_hit = 1'b1;
    unique case (bus_addr)
      OFS_CYC_LO:              rd_mux = cyc_val[DATA_W-1:0];
      OFS_CYC_HI:              rd_mux = cyc_val[2*DATA_W-1:DATA_W];
      OFS_EN_SET, OFS_EN_CLR:  rd_mux = en_q;
      OFS_IE_SET, OFS_IE_CLR:  rd_mux = ie_q;
      OFS_STS_CLR, OFS_STS_SET: rd_mux = status;
      OFS_CFG:                 rd_mux = CFG;
      OFS_CTRL:                rd_mux = {31'b0, gl_en};
      default: begin
        rd_hit = 1'b0;
        for (int i = 0; i < NUM_EV; i++) begin
          if (bus_addr == cnt_ofs(i)) begin
            rd_mux = ev_val[i];
            rd_hit = 1'b1;
          end
          if (bus_addr == tag_ofs(i)) begin
            rd_mux = {{(DATA_W-TAG_W){1'b0}}, tag_q[i]};
            rd_hit = 1'b1;
          end
        end
      end
    endcase
  end

  assign bus_rdata = rd ? rd_mux : '0;
  assign irq       = |(status & ie_q);

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int NUM_EV = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [11:0]       bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic              gl_en,
  input logic [63:0]       cyc_val,
  input logic              cyc_wr,
  input logic              cyc_clr,
  input logic [NUM_EV-1:0] ev_wrap,
  input logic              cyc_wrap,
  input logic [31:0]       status,
  input logic [31:0]       ie_q,
  input logic              sts_clr_wr,
  input logic              rd_hit
);
  import pcu_pkg::*;

  // R4: the cycle counter holds while the run bit is off
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gl_en && !cyc_wr && !cyc_clr) |=> (cyc_val == $past(cyc_val)));

  // R6: an event wrap shows in status after that edge
  p_ev_wrap_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wrap != '0) |=> ((status[NUM_EV-1:0] & $past(ev_wrap)) == $past(ev_wrap)));

  p_cyc_wrap_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_wrap |=> status[CYC_BIT]);

  // R7: without a clear write no status bit drops
  p_sticky_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_clr_wr |=> ((status & $past(status)) == $past(status)));

  // R8: no interrupt while every interrupt enable is off
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q == '0) |-> !irq);

  // R9: reset commands never read back
  p_ctrl_selfclear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == OFS_CTRL) |-> (bus_rdata[2:1] == 2'b00));

  // R10: unmapped reads return zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && !rd_hit) |-> (bus_rdata == '0));

endmodule

bind perf_counter_unit pcu_checker #(.NUM_EV(NUM_EV)) i_pcu_checker (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq(irq), .gl_en(gl_en),
  .cyc_val(cyc_val), .cyc_wr(cyc_wr), .cyc_clr(cyc_clr), .ev_wrap(ev_wrap),
  .cyc_wrap(cyc_wrap), .status(status), .ie_q(ie_q), .sts_clr_wr(sts_clr_wr),
  .rd_hit(rd_hit));

// File: tb/test_perf_counter_unit.sv
`timescale 1ns/1ps
module test_perf_counter_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  evt_strobe = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  perf_counter_unit i_perf_counter_unit (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_strobe(evt_strobe), .irq(irq));

  // Vector: {req[3:0], is_write, addr[11:0], data[31:0]}; data is expectation on reads
  localparam int NV = 25;
  localparam logic [48:0] VEC [NV] = '{
    {4'd2,  1'b1, 12'h008, 32'h1234_5678},
    {4'd2,  1'b0, 12'h008, 32'h1234_5678},  // R2 counter 0
    {4'd2,  1'b1, 12'h040, 32'hA5A5_0001},
    {4'd2,  1'b0, 12'h040, 32'hA5A5_0001},  // R2 counter 7
    {4'd2,  1'b1, 12'h0F8, 32'hDEAD_BEEF},
    {4'd2,  1'b1, 12'h0FC, 32'h8000_0000},
    {4'd2,  1'b0, 12'h0F8, 32'hDEAD_BEEF},
    {4'd2,  1'b0, 12'h0FC, 32'h8000_0000},  // R2 cycle high preload
    {4'd3,  1'b1, 12'h41C, 32'hFFFF_FFFF},
    {4'd3,  1'b0, 12'h41C, 32'h0000_1FFF},  // R3 tag keeps 12:0
    {4'd3,  1'b0, 12'hE00, 32'h0000_2008},  // R3 config word
    {4'd5,  1'b1, 12'hC00, 32'hFFFF_FFFF},
    {4'd5,  1'b0, 12'hC00, 32'h8000_00FF},  // R5 implemented bits
    {4'd5,  1'b1, 12'hC20, 32'h0000_0011},
    {4'd5,  1'b0, 12'hC20, 32'h8000_00EE},  // R5 zero bits untouched
    {4'd5,  1'b1, 12'hC40, 32'h8000_0004},
    {4'd5,  1'b0, 12'hC60, 32'h8000_0004},  // R5 interrupt mask
    {4'd10, 1'b1, 12'h0F4, 32'hFFFF_FFFF},
    {4'd10, 1'b0, 12'h0F4, 32'h0000_0000},  // R10 unmapped
    {4'd10, 1'b1, 12'h00C, 32'hFFFF_FFFF},
    {4'd10, 1'b0, 12'h00C, 32'h0000_0000},  // R10 odd word
    {4'd9,  1'b1, 12'hE04, 32'h0000_0006},
    {4'd9,  1'b0, 12'hE04, 32'h0000_0000},  // R9 self-clearing
    {4'd9,  1'b0, 12'h008, 32'h0000_0000},  // R9 event reset
    {4'd9,  1'b0, 12'h0FC, 32'h0000_0000}   // R9 cycle reset
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
    bus_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd_chk("R1 enables", 12'hC00, 32'h0);
    rd_chk("R1 int enables", 12'hC40, 32'h0);
    rd_chk("R1 status", 12'hC80, 32'h0);
    rd_chk("R1 control", 12'hE04, 32'h0);
    rd_chk("R1 counter", 12'h010, 32'h0);
    rd_chk("R1 cycle", 12'h0F8, 32'h0);
    rd_chk("R1 tag", 12'h400, 32'h0);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][44]) wr(VEC[i][43:32], VEC[i][31:0]);
      else rd_chk($sformatf("R%0d vector %0d", VEC[i][48:45], i), VEC[i][43:32], VEC[i][31:0]);
    end
    wr(12'hC20, 32'hFFFF_FFFF);
    wr(12'hC60, 32'hFFFF_FFFF);

    // R4 and R6: counter 2 wraps, counter 1 not enabled
    wr(12'h018, 32'hFFFF_FFFE);
    wr(12'hC00, 32'h0000_0004);
    wr(12'hC40, 32'h0000_0004);
    wr(12'hE04, 32'h0000_0001);
    evt_strobe = 8'b0000_0110;
    idle(2);
    evt_strobe = '0;
    rd_chk("R6 wrap to zero", 12'h018, 32'h0);
    rd_chk("R4 disabled counter holds", 12'h010, 32'h0);
    rd_chk("R6 status bit", 12'hC80, 32'h0000_0004);
    idle(4);
    check("R8 irq held", {31'b0, irq}, 32'h1);
    wr(12'hC80, 32'h0000_0004);
    check("R8 irq after clear", {31'b0, irq}, 32'h0);

    // R4 counting of strobes
    wr(12'hC00, 32'h0000_0001);
    evt_strobe = 8'b0000_0001;
    idle(5);
    evt_strobe = '0;
    rd_chk("R4 five strobes", 12'h008, 32'h0000_0005);

    // R11 write beats count
    evt_strobe = 8'b0000_0001;
    wr(12'h008, 32'h0000_0100);
    evt_strobe = '0;
    rd_chk("R11 write priority", 12'h008, 32'h0000_0100);

    // R7 hardware set beats software clear
    wr(12'hE04, 32'h0);
    wr(12'h020, 32'hFFFF_FFFF);
    wr(12'hC00, 32'h0000_0008);
    wr(12'hE04, 32'h1);
    evt_strobe = 8'b0000_1000;
    wr(12'hC80, 32'h0000_0008);
    evt_strobe = '0;
    rd_chk("R7 hw wins", 12'hCC0, 32'h0000_0008);
    wr(12'hE04, 32'h0);

    // R4 cycle counter carry
    wr(12'hC00, 32'h8000_0000);
    wr(12'h0F8, 32'hFFFF_FFFF);
    wr(12'h0FC, 32'h0000_0005);
    wr(12'hE04, 32'h1);
    idle(3);
    wr(12'hE04, 32'h0);
    rd_chk("R4 cycle low", 12'h0F8, 32'h0000_0003);
    rd_chk("R4 cycle high", 12'h0FC, 32'h0000_0006);

    // R6 and R8 cycle wrap
    wr(12'hC40, 32'h8000_0000);
    wr(12'h0F8, 32'hFFFF_FFFF);
    wr(12'h0FC, 32'hFFFF_FFFF);
    wr(12'hE04, 32'h1);
    wr(12'hE04, 32'h0);
    rd_chk("R6 cycle wraps", 12'h0FC, 32'h0);
    rd_chk("R6 cycle status", 12'hC80, 32'h8000_0008);
    check("R8 cycle irq", {31'b0, irq}, 32'h1);

    // R7 software set, R9 cycle-only reset
    wr(12'hCC0, 32'h0000_0040);
    rd_chk("R7 software set", 12'hC80, 32'h8000_0048);
    wr(12'h0F8, 32'h0000_0077);
    wr(12'hE04, 32'h0000_0004);
    rd_chk("R9 cycle zeroed", 12'h0F8, 32'h0);
    rd_chk("R9 events kept", 12'h008, 32'h0000_0100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule